// File: doc/BRIEF.md
# Thermal Energy Budget Governor

This block decides once per control interval whether the package may run above its sustained power limit. An interval strobe `tick` marks each interval. With each strobe the block takes one measured power sample and moves an energy-credit store by the gap between the sustained limit and that sample. The store fills while the package draws less than the limit, for example while idle, and empties while it draws more. The store never goes below zero and never goes above a programmable ceiling.

From the credit store the block derives a turbo grant. The grant uses two programmable thresholds, one to enter turbo and a lower one to leave it. While the grant is off, the frequency level is the guaranteed base level. While it is on, the level comes from a small programmable table indexed by the number of active cores, so fewer active cores may run faster. The package power allowance is the turbo allowance while turbo is granted and the sustained limit otherwise. That allowance is split between the core domain and the graphics domain, and any part a domain does not need goes to the other domain. Under a steady load above the limit the credit runs out and the allowance falls back to the sustained limit.

All outputs are registered and change only at a clock edge where `tick` is high.

Top module: `energy_budget_governor`

## Requirements
- R1: A synchronous active-high `rst` clears `budget`, `turbo_on`, `freq_lvl`, `core_alloc` and `gfx_alloc` to zero. They stay zero until the first `tick` after reset.
- R2: At every clock edge where `tick` is low, all outputs keep their values, whatever the other inputs do.
- R3: At a `tick` edge the new budget is `budget + sus_limit - meas_pwr`, limited to no less than 0 and no more than `budget_ceil`. A budget left above a ceiling that has been lowered is brought down to the new ceiling.
- R4: The new turbo flag is 1 when the new budget is greater than `off_thr` and either the flag was already 1 or the new budget is at least `on_thr`. Otherwise the new flag is 0.
- R5: When the new turbo flag is 0, `freq_lvl` becomes `base_lvl`.
- R6: When the new turbo flag is 1, `freq_lvl` becomes the larger of `base_lvl` and table entry n. Here n is the number of ones in `core_active`, and entry n sits in bits `[n*LVL_W +: LVL_W]` of `lvl_table`.
- R7: The total allowance is `pkg_allow` when the new turbo flag is 1 and `sus_limit` when it is 0. `core_alloc + gfx_alloc` never exceeds the total. Neither allocation exceeds its own domain's demand.
- R8: The split of the total T works as follows. The core half is `T - floor(T/2)` and the graphics half is `floor(T/2)`. If the core demand is below the core half, the core gets its demand and graphics gets the smaller of its demand and T minus the core demand. Otherwise, if the graphics demand is below the graphics half, graphics gets its demand and the core gets the smaller of its demand and T minus the graphics demand. Otherwise each domain gets its half.
- R9: A steady load with `meas_pwr` above `sus_limit` drains `budget` to 0. Turbo is then withdrawn, and the allowance returns to `sus_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Control-interval strobe, one cycle per interval |
| meas_pwr | input | PWR_W | Measured power sample for the interval |
| sus_limit | input | PWR_W | Sustained power limit |
| pkg_allow | input | PWR_W | Package power allowance while turbo is granted |
| budget_ceil | input | BUD_W | Ceiling of the energy credit |
| on_thr | input | BUD_W | Credit level at which turbo is entered |
| off_thr | input | BUD_W | Credit level at or below which turbo is left |
| core_active | input | N_CORE | One bit per core, 1 when the core is powered and active |
| lvl_table | input | (N_CORE+1)*LVL_W | Turbo level per active-core count, entry n at bits n*LVL_W |
| base_lvl | input | LVL_W | Guaranteed frequency level |
| core_demand | input | PWR_W | Power requested by the core domain |
| gfx_demand | input | PWR_W | Power requested by the graphics domain |
| budget | output | BUD_W | Current energy credit |
| turbo_on | output | 1 | Turbo grant |
| freq_lvl | output | LVL_W | Granted frequency level |
| core_alloc | output | PWR_W | Power allowed to the core domain |
| gfx_alloc | output | PWR_W | Power allowed to the graphics domain |

## Verification
On every cycle, the assertions check the following. The credit never exceeds the ceiling seen at the last strobe. A grant is never held with the credit at or below the exit threshold. The two allocations never sum above the allowance and never exceed their demands. The frequency level never drops below the base level. Nothing moves between strobes. Only the bench's scenarios can show the exact values: credit filling to the ceiling while idle and then draining, the hysteresis band where the grant holds between the two thresholds, the table lookup for each active-core count, and the handover of unused power between the domains with odd and even totals.

// File: rtl/egov_pkg.sv
package egov_pkg;

    typedef enum logic {
        GRANT_BASE  = 1'b0,
        GRANT_TURBO = 1'b1
    } grant_e;

    function automatic logic [31:0] umin32(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] umax32(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/egov_credit.sv
module egov_credit
    import egov_pkg::*;
#(
    parameter int PWR_W = 12,
    parameter int BUD_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PWR_W-1:0] meas_pwr,
    input  logic [PWR_W-1:0] sus_limit,
    input  logic [BUD_W-1:0] budget_ceil,
    input  logic [BUD_W-1:0] on_thr,
    input  logic [BUD_W-1:0] off_thr,
    output logic [BUD_W-1:0] budget_q,
    output grant_e           grant_q,
    output grant_e           grant_nxt
);
    localparam int SW = BUD_W + 2;

    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] ceil_s;
    logic [BUD_W-1:0]     bud_nxt;
    logic                 may_enter;
    logic                 may_stay;

    always_comb begin
        sum_s  = $signed({2'b00, budget_q})
               + $signed({{(SW-PWR_W){1'b0}}, sus_limit})
               - $signed({{(SW-PWR_W){1'b0}}, meas_pwr});
        ceil_s = $signed({2'b00, budget_ceil});
        if (sum_s < 0) begin
            bud_nxt = '0;
        end else if (sum_s > ceil_s) begin
            bud_nxt = budget_ceil;
        end else begin
            bud_nxt = sum_s[BUD_W-1:0];
        end
    end

    always_comb begin
        may_stay  = (bud_nxt > off_thr);
        may_enter = (bud_nxt >= on_thr);
        if (may_stay && ((grant_q == GRANT_TURBO) || may_enter)) begin
            grant_nxt = GRANT_TURBO;
        end else begin
            grant_nxt = GRANT_BASE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            budget_q <= '0;
            grant_q  <= GRANT_BASE;
        end else if (tick) begin
            budget_q <= bud_nxt;
            grant_q  <= grant_nxt;
        end
    end

    AST_BUDGET_CEIL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick)) |-> (budget_q <= $past(budget_ceil))); // R3

    AST_DRAIN_DIR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && ($past(meas_pwr) >= $past(sus_limit)))
            |-> (budget_q <= $past(budget_q))); // R3

    AST_GRANT_ABOVE_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && (grant_q == GRANT_TURBO))
            |-> (budget_q > $past(off_thr))); // R4

    AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> ($stable(budget_q) && $stable(grant_q))); // R2

endmodule

// File: rtl/egov_level.sv
module egov_level
    import egov_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int LVL_W  = 4
) (
    input  logic [N_CORE-1:0]            core_active,
    input  logic [(N_CORE+1)*LVL_W-1:0]  lvl_table,
    input  logic [LVL_W-1:0]             base_lvl,
    input  grant_e                       grant,
    output logic [LVL_W-1:0]             lvl_nxt
);
    localparam int N_ENT = N_CORE + 1;
    localparam int CNT_W = $clog2(N_ENT);

    logic [LVL_W-1:0] entry [N_ENT];
    logic [CNT_W-1:0] n_active;
    logic [LVL_W-1:0] picked;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_unpack
        assign entry[gi] = lvl_table[gi*LVL_W +: LVL_W];
    end

    always_comb begin
        n_active = '0;
        for (int i = 0; i < N_CORE; i++) begin
            n_active = n_active + CNT_W'(core_active[i]);
        end
    end

    always_comb begin
        picked = base_lvl;
        for (int e = 0; e < N_ENT; e++) begin
            if (n_active == CNT_W'(e)) begin
                picked = LVL_W'(umax32(32'(entry[e]), 32'(base_lvl)));
            end
        end
        lvl_nxt = (grant == GRANT_TURBO) ? picked : base_lvl;
    end

endmodule

// File: rtl/egov_split.sv
module egov_split
    import egov_pkg::*;
#(
    parameter int PWR_W = 12
) (
    input  logic [PWR_W-1:0] total,
    input  logic [PWR_W-1:0] core_demand,
    input  logic [PWR_W-1:0] gfx_demand,
    output logic [PWR_W-1:0] core_nxt,
    output logic [PWR_W-1:0] gfx_nxt
);
    logic [PWR_W-1:0] half_gfx;
    logic [PWR_W-1:0] half_core;

    always_comb begin
        half_gfx  = total >> 1;
        half_core = total - half_gfx;
        if (core_demand < half_core) begin
            core_nxt = core_demand;
            gfx_nxt  = PWR_W'(umin32(32'(gfx_demand), 32'(total - core_demand)));
        end else if (gfx_demand < half_gfx) begin
            gfx_nxt  = gfx_demand;
            core_nxt = PWR_W'(umin32(32'(core_demand), 32'(total - gfx_demand)));
        end else begin
            core_nxt = half_core;
            gfx_nxt  = half_gfx;
        end
    end

endmodule

// File: rtl/energy_budget_governor.sv
module energy_budget_governor
    import egov_pkg::*;
#(
    parameter int PWR_W  = 12,
    parameter int BUD_W  = 20,
    parameter int N_CORE = 4,
    parameter int LVL_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic [PWR_W-1:0]            meas_pwr,
    input  logic [PWR_W-1:0]            sus_limit,
    input  logic [PWR_W-1:0]            pkg_allow,
    input  logic [BUD_W-1:0]            budget_ceil,
    input  logic [BUD_W-1:0]            on_thr,
    input  logic [BUD_W-1:0]            off_thr,
    input  logic [N_CORE-1:0]           core_active,
    input  logic [(N_CORE+1)*LVL_W-1:0] lvl_table,
    input  logic [LVL_W-1:0]            base_lvl,
    input  logic [PWR_W-1:0]            core_demand,
    input  logic [PWR_W-1:0]            gfx_demand,
    output logic [BUD_W-1:0]            budget,
    output logic                        turbo_on,
    output logic [LVL_W-1:0]            freq_lvl,
    output logic [PWR_W-1:0]            core_alloc,
    output logic [PWR_W-1:0]            gfx_alloc
);
    grant_e           grant_q;
    grant_e           grant_nxt;
    logic [LVL_W-1:0] lvl_nxt;
    logic [PWR_W-1:0] total_nxt;
    logic [PWR_W-1:0] core_nxt;
    logic [PWR_W-1:0] gfx_nxt;
    logic [LVL_W-1:0] lvl_q;
    logic [PWR_W-1:0] core_q;
    logic [PWR_W-1:0] gfx_q;

    egov_credit #(.PWR_W(PWR_W), .BUD_W(BUD_W)) u_credit (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .meas_pwr   (meas_pwr),
        .sus_limit  (sus_limit),
        .budget_ceil(budget_ceil),
        .on_thr     (on_thr),
        .off_thr    (off_thr),
        .budget_q   (budget),
        .grant_q    (grant_q),
        .grant_nxt  (grant_nxt)
    );

    egov_level #(.N_CORE(N_CORE), .LVL_W(LVL_W)) u_level (
        .core_active(core_active),
        .lvl_table  (lvl_table),
        .base_lvl   (base_lvl),
        .grant      (grant_nxt),
        .lvl_nxt    (lvl_nxt)
    );

    assign total_nxt = (grant_nxt == GRANT_TURBO) ? pkg_allow : sus_limit;

    egov_split #(.PWR_W(PWR_W)) u_split (
        .total      (total_nxt),
        .core_demand(core_demand),
        .gfx_demand (gfx_demand),
        .core_nxt   (core_nxt),
        .gfx_nxt    (gfx_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            core_q <= '0;
            gfx_q  <= '0;
        end else if (tick) begin
            lvl_q  <= lvl_nxt;
            core_q <= core_nxt;
            gfx_q  <= gfx_nxt;
        end
    end

    assign turbo_on   = (grant_q == GRANT_TURBO);
    assign freq_lvl   = lvl_q;
    assign core_alloc = core_q;
    assign gfx_alloc  = gfx_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (budget == '0 && !turbo_on && freq_lvl == '0
                        && core_alloc == '0 && gfx_alloc == '0)); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick))
            |-> ($stable(freq_lvl) && $stable(core_alloc) && $stable(gfx_alloc))); // R2

    AST_BASE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && !turbo_on) |-> (freq_lvl == $past(base_lvl))); // R5

    AST_LVL_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && turbo_on) |-> (freq_lvl >= $past(base_lvl))); // R6

    AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick))
            |-> ((PWR_W+1)'(core_alloc) + (PWR_W+1)'(gfx_alloc)
                 <= (PWR_W+1)'(turbo_on ? $past(pkg_allow) : $past(sus_limit)))); // R7

    AST_DEMAND_CAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick))
            |-> (core_alloc <= $past(core_demand) && gfx_alloc <= $past(gfx_demand))); // R7

endmodule

// File: tb/energy_budget_governor_tb.sv
module energy_budget_governor_tb;
    localparam int PWR_W  = 12;
    localparam int BUD_W  = 20;
    localparam int N_CORE = 4;
    localparam int LVL_W  = 4;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic                        tick = 1'b0;
    logic [PWR_W-1:0]            meas_pwr = '0;
    logic [PWR_W-1:0]            sus_limit = 12'd100;
    logic [PWR_W-1:0]            pkg_allow = 12'd160;
    logic [BUD_W-1:0]            budget_ceil = 20'd1000;
    logic [BUD_W-1:0]            on_thr = 20'd500;
    logic [BUD_W-1:0]            off_thr = 20'd200;
    logic [N_CORE-1:0]           core_active = 4'b1111;
    logic [(N_CORE+1)*LVL_W-1:0] lvl_table = 20'h89ACC;
    logic [LVL_W-1:0]            base_lvl = 4'd5;
    logic [PWR_W-1:0]            core_demand = 12'd90;
    logic [PWR_W-1:0]            gfx_demand = 12'd90;
    logic [BUD_W-1:0]            budget;
    logic                        turbo_on;
    logic [LVL_W-1:0]            freq_lvl;
    logic [PWR_W-1:0]            core_alloc;
    logic [PWR_W-1:0]            gfx_alloc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    energy_budget_governor #(
        .PWR_W(PWR_W), .BUD_W(BUD_W), .N_CORE(N_CORE), .LVL_W(LVL_W)
    ) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .meas_pwr(meas_pwr),
        .sus_limit(sus_limit), .pkg_allow(pkg_allow), .budget_ceil(budget_ceil),
        .on_thr(on_thr), .off_thr(off_thr), .core_active(core_active),
        .lvl_table(lvl_table), .base_lvl(base_lvl), .core_demand(core_demand),
        .gfx_demand(gfx_demand), .budget(budget), .turbo_on(turbo_on),
        .freq_lvl(freq_lvl), .core_alloc(core_alloc), .gfx_alloc(gfx_alloc)
    );

    // behavioural reference state
    int m_bud = 0, m_turbo = 0, m_lvl = 0, m_ca = 0, m_ga = 0;
    int t_new, t_cnt, t_ent, t_tot, t_cd, t_gd;

    always @(posedge clk) begin
        if (rst) begin
            m_bud = 0; m_turbo = 0; m_lvl = 0; m_ca = 0; m_ga = 0;
        end else if (tick) begin
            t_new = m_bud + int'(sus_limit) - int'(meas_pwr);
            if (t_new < 0) t_new = 0;
            if (t_new > int'(budget_ceil)) t_new = int'(budget_ceil);
            m_bud = t_new;
            m_turbo = (t_new > int'(off_thr) && (m_turbo == 1 || t_new >= int'(on_thr))) ? 1 : 0;
            t_cnt = $countones(core_active);
            t_ent = int'((lvl_table >> (t_cnt * LVL_W)) & 20'hF);
            if (m_turbo == 1) m_lvl = (t_ent > int'(base_lvl)) ? t_ent : int'(base_lvl);
            else m_lvl = int'(base_lvl);
            t_tot = (m_turbo == 1) ? int'(pkg_allow) : int'(sus_limit);
            t_cd = int'(core_demand);
            t_gd = int'(gfx_demand);
            if (t_cd < t_tot - t_tot / 2) begin
                m_ca = t_cd;
                m_ga = (t_gd < t_tot - t_cd) ? t_gd : t_tot - t_cd;
            end else if (t_gd < t_tot / 2) begin
                m_ga = t_gd;
                m_ca = (t_cd < t_tot - t_gd) ? t_cd : t_tot - t_gd;
            end else begin
                m_ca = t_tot - t_tot / 2;
                m_ga = t_tot / 2;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R3", "budget", int'(budget), m_bud);
            chk("R4", "turbo_on", int'(turbo_on), m_turbo);
            chk("R6", "freq_lvl", int'(freq_lvl), m_lvl);
            chk("R8", "core_alloc", int'(core_alloc), m_ca);
            chk("R8", "gfx_alloc", int'(gfx_alloc), m_ga);
        end
    end

    task automatic do_tick(input int pwr);
        meas_pwr = PWR_W'(pwr);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "budget after reset", int'(budget), 0);
        chk("R1", "turbo after reset", int'(turbo_on), 0);
        chk("R1", "alloc after reset", int'(core_alloc) + int'(gfx_alloc), 0);

        // idle: +90 per interval, saturates at ceiling 1000
        for (int i = 0; i < 14; i++) do_tick(10);
        chk("R3", "budget at ceiling", int'(budget), 1000);
        chk("R4", "turbo granted", int'(turbo_on), 1);
        chk("R6", "level with 4 active", int'(freq_lvl), 8);

        // active-core table lookup, load equal to limit
        core_active = 4'b0001; do_tick(100);
        chk("R6", "level with 1 active", int'(freq_lvl), 12);
        core_active = 4'b0011; do_tick(100);
        chk("R6", "level with 2 active", int'(freq_lvl), 10);
        core_active = 4'b0111; do_tick(100);
        core_active = 4'b0000; do_tick(100);
        core_active = 4'b1111; base_lvl = 4'd11; do_tick(100);
        chk("R6", "entry below base", int'(freq_lvl), 11);
        base_lvl = 4'd5;

        // domain split patterns, total 160 under turbo
        core_demand = 12'd30;  gfx_demand = 12'd200; do_tick(100);
        chk("R8", "gfx takes core leftover", int'(gfx_alloc), 130);
        core_demand = 12'd200; gfx_demand = 12'd20;  do_tick(100);
        chk("R8", "core takes gfx leftover", int'(core_alloc), 140);
        core_demand = 12'd200; gfx_demand = 12'd200; do_tick(100);
        chk("R7", "sum at total", int'(core_alloc) + int'(gfx_alloc), 160);
        core_demand = 12'd10;  gfx_demand = 12'd10;  do_tick(100);
        chk("R7", "below demand", int'(gfx_alloc), 10);
        pkg_allow = 12'd161; core_demand = 12'd300; gfx_demand = 12'd300; do_tick(100);
        chk("R8", "odd total core half", int'(core_alloc), 81);

        // no strobe: inputs move, outputs hold
        meas_pwr = 12'd4000; core_demand = 12'd1; base_lvl = 4'd2; core_active = 4'b0001;
        repeat (20) @(negedge clk);
        chk("R2", "budget held", int'(budget), 1000);
        chk("R2", "core alloc held", int'(core_alloc), 81);
        base_lvl = 4'd5; core_active = 4'b1111; core_demand = 12'd300;

        // lowered ceiling pulls budget down
        budget_ceil = 20'd300; do_tick(100);
        chk("R3", "clamped to new ceiling", int'(budget), 300);
        chk("R4", "still granted above off", int'(turbo_on), 1);

        // sustained heavy load drains credit
        do_tick(250);
        chk("R4", "grant dropped at 150", int'(turbo_on), 0);
        chk("R5", "base level when off", int'(freq_lvl), 5);
        do_tick(250); do_tick(250);
        chk("R9", "budget drained", int'(budget), 0);
        chk("R9", "allowance back to limit", int'(core_alloc) + int'(gfx_alloc), 100);

        // hysteresis band: rise in steps of 60, then fall in steps of 30
        budget_ceil = 20'd1000;
        for (int i = 0; i < 8; i++) do_tick(40);
        chk("R4", "not granted below enter", int'(turbo_on), 0);
        do_tick(40);
        chk("R4", "granted at 540", int'(turbo_on), 1);
        for (int i = 0; i < 11; i++) do_tick(130);
        chk("R4", "held at 210 in band", int'(turbo_on), 1);
        do_tick(130);
        chk("R4", "released at 180", int'(turbo_on), 0);

        // reset in mid-run
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R1", "budget after mid reset", int'(budget), 0);
        chk("R1", "level after mid reset", int'(freq_lvl), 0);
        do_tick(10);
        chk("R3", "first interval after reset", int'(budget), 90);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule